// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a synchronous DRAM from reset to the point where ordinary traffic may start. After reset it holds the memory in a quiet state for a clock-counted pause. During the pause the clock enable and the data mask stay high and the command pins carry NOP. It then closes every bank with one precharge-all and writes the mode register from the mode inputs. Last, it issues a fixed number of auto refreshes. Each step keeps a minimum distance in clocks from the one before it.

When the wait after the final refresh has run out, the block raises a done flag and drops the data mask. From then on it only drives NOP, so the main scheduler can take over the pins. The pause length is derived from the clock frequency parameter. The command spacings are parameters in clocks. The CAS latency is fixed at elaboration, and only the values 2 and 3 are legal.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is asserted, the pins carry NOP (chip select low, row strobe, column strobe and write enable high), clock enable and data mask are high, and the done flag is low.
- R2: After reset is released, the block drives NOP with clock enable and data mask high for exactly PAUSE_US*CLK_MHZ clocks.
- R3: The first command after the pause is precharge-all: chip select low, row strobe low, column strobe high, write enable low, address bit 10 high, all other address bits and both bank bits low.
- R4: The mode register write follows the precharge-all after exactly T_RP clocks, with only NOP in between.
- R5: The mode register write uses chip select, row strobe, column strobe and write enable all low, with bank bits 00, and clock enable has been high in the clock before it.
- R6: In the mode register write cycle, the address carries the mode word taken from the inputs of that same cycle. Bits 2:0 hold the burst length code and bit 3 the burst type. Bits 6:4 hold the CAS latency code, 010 for 2 and 011 for 3. Bit 9 selects single-write mode. Every other bit is 0.
- R7: The first auto refresh follows the mode register write after exactly T_MRD clocks, with only NOP in between.
- R8: Exactly REF_COUNT auto refreshes are issued, each with chip select, row strobe and column strobe low and write enable high. Consecutive refreshes are exactly T_RC clocks apart, with NOP in between.
- R9: The done flag rises exactly T_RC clocks after the last refresh. It then stays high, and in the same cycle the data mask goes low.
- R10: Every cycle that carries no sequence command carries NOP, and clock enable is never low.
- R11: A full run issues one precharge-all, then one mode register write, then the refreshes, and no other command. A reset in mid-sequence restarts the whole order from the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_len_code | input | 3 | Burst length code for mode bits 2:0 |
| burst_interleave | input | 1 | Burst type for mode bit 3 (1 = interleaved) |
| single_write | input | 1 | 1 selects burst read with single write (mode bit 9) |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dqm | output | 1 | Data mask, high until done |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus, carries the mode word during the mode write |
| init_done | output | 1 | High once the sequence has completed |

## Verification
Two things can land in one cycle: a change of the mode inputs and the issue of the mode register write. The bench changes the mode inputs on every clock, so the word sampled in the write cycle must match the inputs of that cycle and not those of the cycle before. The expiry of the last refresh spacing and the rise of the done flag must also coincide with the fall of the data mask. A behavioural model predicts the exact clock of each event from the parameters. A reset issued in the middle of the refresh train checks that the sequence starts over from the pause.

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq #(
  parameter int CLK_MHZ   = 100,
  parameter int PAUSE_US  = 200,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int T_RC      = 7,
  parameter int REF_COUNT = 8,
  parameter int CAS_LAT   = 3,
  parameter int ADDR_W    = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        burst_len_code,
  input  logic              burst_interleave,
  input  logic              single_write,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              dqm,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int PAUSE_CLKS = PAUSE_US * CLK_MHZ;
  localparam int MAX_A = (PAUSE_CLKS > T_RC) ? PAUSE_CLKS : T_RC;
  localparam int MAX_B = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAXW  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXW + 1);
  localparam int RW    = $clog2(REF_COUNT + 1);
  localparam logic [CW-1:0] PAUSE_LD = CW'(PAUSE_CLKS - 1);
  localparam logic [CW-1:0] RP_LD    = CW'(T_RP - 2);
  localparam logic [CW-1:0] MRD_LD   = CW'(T_MRD - 2);
  localparam logic [CW-1:0] RC_LD    = CW'(T_RC - 2);

  if (CAS_LAT != 2 && CAS_LAT != 3) begin : g_bad_cas
    $error("sdram_powerup_seq: CAS_LAT must be 2 or 3");
  end
  if (T_RP < 2 || T_MRD < 2 || T_RC < 2 || REF_COUNT < 1 || ADDR_W < 11 || PAUSE_CLKS < 1) begin : g_bad_timing
    $error("sdram_powerup_seq: illegal timing or width parameter");
  end

  typedef enum logic [2:0] {
    S_PAUSE, S_PRE, S_RP, S_MRS, S_MRD, S_REF, S_RC, S_DONE
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [RW-1:0] refs_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PAUSE;
      cnt       <= PAUSE_LD;
      refs_left <= RW'(REF_COUNT);
    end else begin
      case (st)
        S_PAUSE: if (cnt == '0) st <= S_PRE; else cnt <= cnt - 1'b1;
        S_PRE: begin
          st  <= S_RP;
          cnt <= RP_LD;
        end
        S_RP:  if (cnt == '0) st <= S_MRS; else cnt <= cnt - 1'b1;
        S_MRS: begin
          st  <= S_MRD;
          cnt <= MRD_LD;
        end
        S_MRD: if (cnt == '0) st <= S_REF; else cnt <= cnt - 1'b1;
        S_REF: begin
          st        <= S_RC;
          cnt       <= RC_LD;
          refs_left <= refs_left - 1'b1;
        end
        S_RC: begin
          if (cnt == '0) st <= (refs_left == '0) ? S_DONE : S_REF;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_DONE;
      endcase
    end
  end

  wire issue_pre = (st == S_PRE);
  wire issue_mrs = (st == S_MRS);
  wire issue_ref = (st == S_REF);

  assign cke       = 1'b1;
  assign cs_n      = 1'b0;
  assign ras_n     = ~(issue_pre | issue_mrs | issue_ref);
  assign cas_n     = ~(issue_mrs | issue_ref);
  assign we_n      = ~(issue_pre | issue_mrs);
  assign ba        = 2'b00;
  assign init_done = (st == S_DONE);
  assign dqm       = ~init_done;

  always_comb begin
    addr = '0;
    if (issue_pre) addr[10] = 1'b1;
    if (issue_mrs) begin
      addr[2:0] = burst_len_code;
      addr[3]   = burst_interleave;
      addr[6:4] = 3'(CAS_LAT);
      addr[9]   = single_write;
    end
  end

  wire pin_nop = !cs_n &&  ras_n &&  cas_n &&  we_n;
  wire pin_pre = !cs_n && !ras_n &&  cas_n && !we_n;
  wire pin_mrs = !cs_n && !ras_n && !cas_n && !we_n;
  wire pin_ref = !cs_n && !ras_n && !cas_n &&  we_n;

  p_pre_then_nop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pre |=> pin_nop);
  p_mrs_bank_cke_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pin_mrs |-> (ba == 2'b00 && cke && $past(cke)));
  p_mrs_then_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_mrs |=> pin_nop);
  p_ref_then_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ref |=> pin_nop);
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (init_done && pin_nop));
  p_done_unmask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $fell(dqm));
  p_one_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pin_pre, pin_mrs, pin_ref}) && (pin_pre || pin_mrs || pin_ref || pin_nop));

endmodule

// File: tb/sdram_powerup_seq_bench.sv
module sdram_powerup_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 1;
  localparam int PAUSE_US   = 200;
  localparam int T_RP       = 3;
  localparam int T_MRD      = 2;
  localparam int T_RC       = 7;
  localparam int REF_COUNT  = 8;
  localparam int CAS_LAT    = 3;
  localparam int ADDR_W     = 13;
  localparam int P          = PAUSE_US * CLK_MHZ;
  localparam int MRS_AT     = P + T_RP;
  localparam int REF0_AT    = MRS_AT + T_MRD;
  localparam int DONE_AT    = REF0_AT + REF_COUNT * T_RC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] burst_len_code = '0;
  logic burst_interleave = 1'b0;
  logic single_write = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, dqm, init_done;
  logic [1:0] ba;
  logic [ADDR_W-1:0] addr;

  int checks = 0;
  int errors = 0;

  sdram_powerup_seq #(
    .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .T_RP(T_RP), .T_MRD(T_MRD),
    .T_RC(T_RC), .REF_COUNT(REF_COUNT), .CAS_LAT(CAS_LAT), .ADDR_W(ADDR_W)
  ) u_sdram_powerup_seq (
    .clk(clk), .rst_n(rst_n), .burst_len_code(burst_len_code),
    .burst_interleave(burst_interleave), .single_write(single_write),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dqm(dqm), .ba(ba), .addr(addr), .init_done(init_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  // 0 NOP, 1 PRE, 2 MRS, 3 REF, -1 anything else
  function automatic int pin_cmd();
    if (cs_n) return -1;
    case ({ras_n, cas_n, we_n})
      3'b111: return 0;
      3'b010: return 1;
      3'b000: return 2;
      3'b001: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic drive_mode(input int k, input int seed);
    burst_len_code   = 3'(k + seed);
    burst_interleave = 1'((k >> 1) + seed);
    single_write     = 1'((k >> 2) ^ seed);
  endtask

  task automatic run_seq(input int stop_at, input int seed);
    int ev_at[$];
    int ev_cmd[$];
    int n_pre = 0, n_mrs = 0, n_ref = 0;
    bit order_ok = 1'b1;
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      #1;
      chk(pin_cmd() == 0, "R1", "reset cmd", pin_cmd(), 0);
      chk(cke && dqm && !init_done, "R1", "reset cke/dqm/done",
          {cke, dqm, init_done}, 3'b110);
    end
    ev_at.push_back(P);      ev_cmd.push_back(1);
    ev_at.push_back(MRS_AT); ev_cmd.push_back(2);
    for (int i = 0; i < REF_COUNT; i++) begin
      ev_at.push_back(REF0_AT + i * T_RC);
      ev_cmd.push_back(3);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k <= stop_at; k++) begin
      int expc;
      string tag;
      logic [ADDR_W-1:0] ew;
      if (k > 0) @(negedge clk);
      drive_mode(k, seed);
      #1;
      expc = 0;
      if (ev_at.size() > 0 && ev_at[0] == k) begin
        expc = ev_cmd[0];
        void'(ev_at.pop_front());
        void'(ev_cmd.pop_front());
      end
      if (expc == 1) tag = "R3";
      else if (expc == 2) tag = "R5";
      else if (expc == 3) tag = "R8";
      else if (k < P) tag = "R2";
      else if (k < MRS_AT) tag = "R4";
      else if (k < REF0_AT) tag = "R7";
      else tag = "R10";
      chk(pin_cmd() == expc, tag, "command", pin_cmd(), expc);
      chk(cke == 1'b1, (k < P) ? "R2" : "R10", "cke", cke, 1);
      chk(dqm == (k < DONE_AT), (k < P) ? "R2" : "R9", "dqm", dqm, (k < DONE_AT));
      chk(init_done == (k >= DONE_AT), "R9", "init_done", init_done, (k >= DONE_AT));
      if (expc == 1)
        chk(addr == ADDR_W'(1 << 10) && ba == 2'b00, "R3", "precharge-all addr", addr, 1 << 10);
      if (expc == 2) begin
        ew = '0;
        ew[2:0] = burst_len_code;
        ew[3]   = burst_interleave;
        ew[6:4] = 3'(CAS_LAT);
        ew[9]   = single_write;
        chk(addr == ew, "R6", "mode word", addr, ew);
        chk(ba == 2'b00, "R5", "mode bank", ba, 0);
      end
      case (pin_cmd())
        1: begin n_pre++; if (n_mrs != 0 || n_ref != 0) order_ok = 1'b0; end
        2: begin n_mrs++; if (n_pre != 1 || n_ref != 0) order_ok = 1'b0; end
        3: begin n_ref++; if (n_mrs != 1) order_ok = 1'b0; end
        default: ;
      endcase
    end
    if (stop_at >= DONE_AT) begin
      chk(n_pre == 1 && n_mrs == 1, "R11", "pre/mrs count", n_pre * 10 + n_mrs, 11);
      chk(n_ref == REF_COUNT, "R8", "refresh count", n_ref, REF_COUNT);
      chk(order_ok, "R11", "command order", order_ok, 1);
    end
  endtask

  initial begin
    run_seq(DONE_AT + 6, 0);
    run_seq(REF0_AT + 3 * T_RC + 2, 5);
    run_seq(DONE_AT + 4, 3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule